// File: doc/BRIEF.md
# Correction-Word Write Coalescing Buffer

This block sits in the write path of a memory controller. Every cache line has a 72-bit correction word. The correction words of eight neighbouring lines share one 72-byte burst that is stored in the same DRAM row as their data. A line write gives a correction-word update to the buffer. The buffer folds that update into a small associative set of pending bursts, keyed by burst address. A burst goes out to DRAM only when its entry is evicted, when a read needs it or when a flush drains the buffer. One correction write can therefore stand for as many as eight data writes. The cost per data write falls between 1.125 and 2 writes, depending on how well the updates merge.

The update input and the burst output are valid/ready streams. A source that raises `upd_valid` keeps `upd_line` and `upd_word` steady until it sees `upd_ready`. The block keeps `out_valid`, `out_addr`, `out_data` and `out_mask` steady until `out_ready`, and it holds pending bursts for as long as `out_ready` stays low. Reads are gated by `rd_ready`. The controller must not issue a read of a burst address until `rd_ready` is high for that address. `flush_req` and `flush_busy` are plain control pins. Two free-running counters report how many data writes and correction writes were accepted.

Top module: `corr_merge_buf`

## Requirements
- R1: After reset, `out_valid` and `flush_busy` are low, `upd_ready` and `rd_ready` are high, and both counters read zero.
- R2: For `upd_line`, bits [2:0] are the slot and the upper bits are the burst address. The word for slot k appears at `out_data[k*72 +: 72]` of that burst.
- R3: An update whose burst address is already pending merges into that entry, and a later update to the same slot replaces the earlier word. Up to eight line writes to one burst leave as a single burst, and no burst is issued while nothing forces it.
- R4: Bit k of `out_mask` is set exactly when slot k was written since the entry was allocated. Every issued burst has a nonzero mask, and unwritten slots carry zero data.
- R5: An update that misses while all entries are occupied is refused (`upd_ready` low). The least recently allocated entry is then evicted. Merging into an entry does not change its age.
- R6: `rd_ready` is low while the requested burst address is pending in an entry or in the output register. A valid read that matches an entry drains that entry ahead of any other.
- R7: A `flush_req` pulse raises `flush_busy` from the next cycle until no entry is pending. All updates are refused in that time.
- R8: While `out_valid` is high and `out_ready` is low, the offered burst stays unchanged in the next cycle.
- R9: `cnt_data_wr` counts accepted updates and `cnt_corr_wr` counts accepted bursts. Both wrap at their width.
- R10: An update that hits the entry being drained in the same cycle is refused. It is accepted later into a fresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Correction-word update offered |
| upd_ready | output | 1 | Update accepted this cycle when high with valid |
| upd_line | input | LINE_W | Cache line index (slot in low bits) |
| upd_word | input | WORD_W | New correction word for the line |
| rd_valid | input | 1 | A read of a burst address is waiting |
| rd_addr | input | LINE_W-3 | Burst address of that read |
| rd_ready | output | 1 | Read may go to DRAM (no pending copy) |
| flush_req | input | 1 | Pulse: drain every pending entry |
| flush_busy | output | 1 | Drain in progress |
| out_valid | output | 1 | Combined burst offered |
| out_ready | input | 1 | Burst taken by the DRAM scheduler |
| out_addr | output | LINE_W-3 | Burst address |
| out_data | output | 8*WORD_W | Eight correction-word slots |
| out_mask | output | 8 | Slot enables for a masked write |
| cnt_data_wr | output | CNT_W | Accepted update count |
| cnt_corr_wr | output | CNT_W | Accepted burst count |

## Verification
The hardest case to reach is an eviction choice that tells least-recently-allocated apart from least-recently-used. Reaching it needs a full buffer, an older entry that was merged into again, and an output register that is still blocked. The stimulus fills all entries while `out_ready` is held low and refreshes the second entry. It then drives two misses in a row and checks the order of the bursts that leave. A second directed case lines up a read conflict with an update to the same burst in the drain cycle. Random traffic over a small address window then keeps the buffer full and mixes reads, flushes and stalls.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int CWB_LINE_W  = 16;
  localparam int CWB_WORD_W  = 72;
  localparam int CWB_SLOTS   = 8;
  localparam int CWB_ENTRIES = 4;
  localparam int CWB_CNT_W   = 16;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cwb_slotline.sv
module cwb_slotline #(
  parameter int BA_W   = 13,
  parameter int WORD_W = 72,
  parameter int SLOTS  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BURST_W = SLOTS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_i,
  input  logic               merge_i,
  input  logic               free_i,
  input  logic [BA_W-1:0]    addr_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               valid_o,
  output logic [BA_W-1:0]    addr_o,
  output logic [SLOTS-1:0]   mask_o,
  output logic [BURST_W-1:0] data_o
);
  logic               valid_q;
  logic [BA_W-1:0]    addr_q;
  logic [SLOTS-1:0]   mask_q;
  logic [BURST_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      data_q  <= '0;
    end else begin
      if (free_i) valid_q <= 1'b0;
      if (alloc_i) begin
        valid_q <= 1'b1;
        addr_q  <= addr_i;
      end
      if (alloc_i || merge_i) begin
        for (int k = 0; k < SLOTS; k++) begin
          if (SLOT_W'(k) == slot_i) begin
            data_q[k*WORD_W +: WORD_W] <= word_i;
            mask_q[k] <= 1'b1;
          end else if (alloc_i) begin
            data_q[k*WORD_W +: WORD_W] <= '0;
            mask_q[k] <= 1'b0;
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign mask_o  = mask_q;
  assign data_o  = data_q;

  // R3: allocation only into an empty line, merging only into a live one
  assert_alloc_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !valid_q);
  assert_merge_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> (valid_q && !free_i));
  // R4: a freshly allocated line holds exactly one written slot
  assert_alloc_one_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> $countones(mask_q) == 1);
endmodule

// File: rtl/cwb_age_rank.sv
module cwb_age_rank #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] alloc_i,
  input  logic [ENTRIES-1:0] free_i,
  output logic [IDX_W-1:0]   oldest_o
);
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] freed_age;
  logic [IDX_W-1:0] best;

  always_comb begin
    freed_age = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (free_i[e]) freed_age = age_q[e];
  end

  always_comb begin
    oldest_o = '0;
    best     = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (valid_i[e] && age_q[e] >= best) begin
        best     = age_q[e];
        oldest_o = IDX_W'(e);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) age_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (alloc_i[e]) begin
          age_q[e] <= '0;
        end else if (valid_i[e] && !free_i[e]) begin
          age_q[e] <= age_q[e]
                    + ((|alloc_i) ? IDX_W'(1) : IDX_W'(0))
                    - (((|free_i) && (age_q[e] > freed_age)) ? IDX_W'(1) : IDX_W'(0));
        end
      end
    end
  end

  // R5: the chosen victim is always a live entry
  assert_victim_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|valid_i) |-> valid_i[oldest_o]);
  assert_single_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_i) && $onehot0(free_i));
endmodule

// File: rtl/corr_merge_buf.sv
module corr_merge_buf
  import cwb_pkg::*;
#(
  parameter int LINE_W  = CWB_LINE_W,
  parameter int WORD_W  = CWB_WORD_W,
  parameter int SLOTS   = CWB_SLOTS,
  parameter int ENTRIES = CWB_ENTRIES,
  parameter int CNT_W   = CWB_CNT_W,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int BA_W    = LINE_W - SLOT_W,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int BURST_W = SLOTS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  output logic               upd_ready,
  input  logic [LINE_W-1:0]  upd_line,
  input  logic [WORD_W-1:0]  upd_word,
  input  logic               rd_valid,
  input  logic [BA_W-1:0]    rd_addr,
  output logic               rd_ready,
  input  logic               flush_req,
  output logic               flush_busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BA_W-1:0]    out_addr,
  output logic [BURST_W-1:0] out_data,
  output logic [SLOTS-1:0]   out_mask,
  output logic [CNT_W-1:0]   cnt_data_wr,
  output logic [CNT_W-1:0]   cnt_corr_wr
);
  logic [SLOT_W-1:0]  upd_slot;
  logic [BA_W-1:0]    upd_ba;
  logic [ENTRIES-1:0] ent_valid, upd_hit, rd_hit;
  logic [ENTRIES-1:0] alloc_vec, merge_vec, free_vec;
  logic [BA_W-1:0]    ent_addr [ENTRIES];
  logic [SLOTS-1:0]   ent_mask [ENTRIES];
  logic [BURST_W-1:0] ent_data [ENTRIES];
  logic [IDX_W-1:0]   hit_idx, rd_idx, free_idx, oldest_idx, drain_sel;
  logic any_hit, any_rd_hit, any_free, rd_conflict, need_room;
  logic drain_want, drain_fire, upd_fire, out_fire;
  logic flushing_q;
  logic               ov_q;
  logic [BA_W-1:0]    oa_q;
  logic [SLOTS-1:0]   om_q;
  logic [BURST_W-1:0] od_q;
  logic [CNT_W-1:0]   cd_q, cc_q;

  assign upd_slot = upd_line[SLOT_W-1:0];
  assign upd_ba   = upd_line[LINE_W-1:SLOT_W];

  // address match and index selection
  always_comb begin
    hit_idx  = '0;
    rd_idx   = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      upd_hit[e] = ent_valid[e] && (ent_addr[e] == upd_ba);
      rd_hit[e]  = ent_valid[e] && (ent_addr[e] == rd_addr);
      if (upd_hit[e]) hit_idx = IDX_W'(e);
      if (rd_hit[e])  rd_idx  = IDX_W'(e);
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!ent_valid[e]) begin
        free_idx = IDX_W'(e);
        any_free = 1'b1;
      end
    end
    any_hit    = |upd_hit;
    any_rd_hit = |rd_hit;
  end

  // drain arbitration: read conflict first, then least recently allocated
  always_comb begin
    rd_conflict = rd_valid && any_rd_hit;
    need_room   = upd_valid && !any_hit && !any_free && !flushing_q;
    drain_want  = rd_conflict || (flushing_q && (|ent_valid)) || need_room;
    drain_sel   = rd_conflict ? rd_idx : oldest_idx;
    drain_fire  = drain_want && (!ov_q || out_ready);
    if (flushing_q)   upd_ready = 1'b0;
    else if (any_hit) upd_ready = !(drain_fire && (drain_sel == hit_idx));
    else              upd_ready = any_free;
    upd_fire = upd_valid && upd_ready;
    out_fire = ov_q && out_ready;
    for (int e = 0; e < ENTRIES; e++) begin
      alloc_vec[e] = upd_fire && !any_hit && (free_idx == IDX_W'(e));
      merge_vec[e] = upd_fire &&  any_hit && (hit_idx  == IDX_W'(e));
      free_vec[e]  = drain_fire && (drain_sel == IDX_W'(e));
    end
  end

  assign rd_ready = !any_rd_hit && !(ov_q && (oa_q == rd_addr));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    cwb_slotline #(.BA_W(BA_W), .WORD_W(WORD_W), .SLOTS(SLOTS)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc_i(alloc_vec[g]),
      .merge_i(merge_vec[g]),
      .free_i (free_vec[g]),
      .addr_i (upd_ba),
      .slot_i (upd_slot),
      .word_i (upd_word),
      .valid_o(ent_valid[g]),
      .addr_o (ent_addr[g]),
      .mask_o (ent_mask[g]),
      .data_o (ent_data[g])
    );
  end

  cwb_age_rank #(.ENTRIES(ENTRIES)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (ent_valid),
    .alloc_i (alloc_vec),
    .free_i  (free_vec),
    .oldest_o(oldest_idx)
  );

  // output register, flush state and counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q       <= 1'b0;
      oa_q       <= '0;
      om_q       <= '0;
      od_q       <= '0;
      flushing_q <= 1'b0;
      cd_q       <= '0;
      cc_q       <= '0;
    end else begin
      if (drain_fire) begin
        ov_q <= 1'b1;
        oa_q <= ent_addr[drain_sel];
        om_q <= ent_mask[drain_sel];
        od_q <= ent_data[drain_sel];
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
      if (flush_req)                         flushing_q <= 1'b1;
      else if (flushing_q && (ent_valid == '0)) flushing_q <= 1'b0;
      if (upd_fire) cd_q <= cd_q + CNT_W'(1);
      if (out_fire) cc_q <= cc_q + CNT_W'(1);
    end
  end

  assign out_valid   = ov_q;
  assign out_addr    = oa_q;
  assign out_mask    = om_q;
  assign out_data    = od_q;
  assign flush_busy  = flushing_q;
  assign cnt_data_wr = cd_q;
  assign cnt_corr_wr = cc_q;

  // R3: one entry per burst address
  assert_unique_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_hit));
  // R4: no empty burst leaves the block
  assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));
  // R8: offered burst held while stalled
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_mask) && $stable(out_data)));
  // R7: flush request starts a drain
  assert_flush_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> flush_busy);
  // R9: burst counter follows handshakes
  assert_corr_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (cnt_corr_wr == $past(cnt_corr_wr) + CNT_W'(1)));
  // R6: a pending burst is never released to a read
  assert_read_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !out_valid) |=> out_valid);
endmodule

// File: tb/corr_merge_buf_tb_top.sv
module corr_merge_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 16, WORD_W = 72, SLOTS = 8, ENTRIES = 4, CNT_W = 16;
  localparam int BA_W = LINE_W - 3;
  localparam int NLINES = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 1'b0, upd_ready;
  logic [LINE_W-1:0] upd_line = '0;
  logic [WORD_W-1:0] upd_word = '0;
  logic rd_valid = 1'b0, rd_ready;
  logic [BA_W-1:0] rd_addr = '0;
  logic flush_req = 1'b0, flush_busy;
  logic out_valid, out_ready = 1'b0;
  logic [BA_W-1:0] out_addr;
  logic [SLOTS*WORD_W-1:0] out_data;
  logic [SLOTS-1:0] out_mask;
  logic [CNT_W-1:0] cnt_data_wr, cnt_corr_wr;

  corr_merge_buf #(.LINE_W(LINE_W), .WORD_W(WORD_W), .SLOTS(SLOTS),
                   .ENTRIES(ENTRIES), .CNT_W(CNT_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errors = 0, acc_cnt = 0, burst_cnt = 0;
  logic [WORD_W-1:0] exp_w [NLINES];
  logic [WORD_W-1:0] dram_w [NLINES];
  logic [BA_W-1:0] log_addr [32];
  logic [SLOTS-1:0] log_mask [32];
  bit hold = 0;
  logic [BA_W-1:0] h_addr;
  logic [SLOTS-1:0] h_mask;
  logic [SLOTS*WORD_W-1:0] h_data;
  bit upd_fired, rd_fired, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [WORD_W-1:0] rnd_word();
    return WORD_W'({$urandom(), $urandom(), $urandom()});
  endfunction

  task automatic tick();
    bit ok;
    #1;
    upd_fired = upd_valid && upd_ready;
    rd_fired  = rd_valid && rd_ready;
    if (hold) begin
      chk(out_valid && out_addr == h_addr && out_mask == h_mask && out_data == h_data,
          "R8", "stalled burst changed", 128'(out_addr), 128'(h_addr));
    end
    hold = out_valid && !out_ready;
    h_addr = out_addr; h_mask = out_mask; h_data = out_data;
    if (rd_fired) begin
      ok = 1;
      for (int s = 0; s < 8; s++)
        if (dram_w[int'(rd_addr)*8+s] != exp_w[int'(rd_addr)*8+s]) ok = 0;
      chk(ok, "R6", "read released before pending burst written", 128'(rd_addr), 0);
    end
    if (out_valid && out_ready) begin
      ok = (out_mask != 0) && (int'(out_addr) < NLINES/8);
      for (int s = 0; s < 8; s++) begin
        if (out_mask[s]) dram_w[int'(out_addr)*8+s] = out_data[s*WORD_W +: WORD_W];
        else if (out_data[s*WORD_W +: WORD_W] != 0) ok = 0;
      end
      chk(ok, "R4", "burst mask/zero slots", 128'(out_mask), 0);
      log_addr[burst_cnt%32] = out_addr;
      log_mask[burst_cnt%32] = out_mask;
      burst_cnt++;
    end
    if (upd_fired) begin
      exp_w[int'(upd_line)] = upd_word;
      acc_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    if (upd_fired) upd_valid = 1'b0;
    if (rd_fired) rd_valid = 1'b0;
  endtask

  task automatic put(input int line, input logic [WORD_W-1:0] w);
    upd_valid = 1'b1; upd_line = LINE_W'(line); upd_word = w;
    for (int i = 0; i < 200 && upd_valid; i++) tick();
  endtask

  task automatic do_flush();
    out_ready = 1'b1; flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    for (int i = 0; i < 200 && (flush_busy || out_valid); i++) tick();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    for (int i = 0; i < NLINES; i++) begin exp_w[i] = '0; dram_w[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!out_valid && !flush_busy && upd_ready && rd_ready, "R1", "reset handshakes",
        {out_valid, flush_busy, upd_ready, rd_ready}, 4'b0011);
    chk(cnt_data_wr == 0 && cnt_corr_wr == 0, "R1", "reset counters",
        {cnt_data_wr, cnt_corr_wr}, 0);
    @(negedge clk);

    // R3 full-burst coalescing
    out_ready = 1'b1;
    for (int s = 0; s < 8; s++) put(8 + s, rnd_word());
    tick(); tick();
    chk(burst_cnt == 0, "R3", "burst issued without cause", burst_cnt, 0);
    do_flush();
    chk(burst_cnt == 1 && log_addr[0] == 1 && log_mask[0] == 8'hFF, "R3",
        "eight writes one burst", {burst_cnt[7:0], 3'(log_addr[0]), log_mask[0]}, {8'd1, 3'd1, 8'hFF});
    chk(cnt_data_wr == 8 && cnt_corr_wr == 1, "R9", "counters after merge",
        {cnt_data_wr, cnt_corr_wr}, {16'd8, 16'd1});

    // R2/R4 partial burst and slot overwrite
    put(18, rnd_word()); put(21, rnd_word()); put(18, rnd_word());
    do_flush();
    chk(log_mask[1] == 8'h24, "R4", "partial mask", log_mask[1], 8'h24);
    chk(dram_w[18] == exp_w[18] && dram_w[21] == exp_w[21] && dram_w[16] == 0, "R2",
        "slot placement and overwrite", dram_w[18], exp_w[18]);

    // R5 least recently allocated eviction
    out_ready = 1'b0;
    base = burst_cnt;
    put(0, rnd_word()); put(9, rnd_word()); put(19, rnd_word()); put(24, rnd_word());
    put(12, rnd_word());
    upd_valid = 1'b1; upd_line = 16'd32; upd_word = rnd_word();
    #1;
    chk(!upd_ready, "R5", "miss on full buffer refused", upd_ready, 0);
    for (int i = 0; i < 20 && upd_valid; i++) tick();
    chk(out_valid && out_addr == 0, "R5", "first victim oldest", 128'(out_addr), 0);
    upd_valid = 1'b1; upd_line = 16'd40; upd_word = rnd_word();
    tick(); tick(); tick();
    chk(upd_valid && out_addr == 0, "R8", "stall keeps burst", 128'(out_addr), 0);
    out_ready = 1'b1;
    for (int i = 0; i < 20 && upd_valid; i++) tick();
    tick(); tick();
    chk(log_addr[base%32] == 0 && log_addr[(base+1)%32] == 1 && log_mask[(base+1)%32] == 8'h12,
        "R5", "allocation order, merge kept age", {3'(log_addr[(base+1)%32]), log_mask[(base+1)%32]},
        {3'd1, 8'h12});
    do_flush();

    // R6/R10 read ordering and drain-cycle collision
    out_ready = 1'b0;
    put(1, rnd_word()); put(50, rnd_word());
    rd_valid = 1'b1; rd_addr = 13'd6;
    upd_valid = 1'b1; upd_line = 16'd51; upd_word = rnd_word();
    #1;
    chk(!rd_ready, "R6", "read of pending burst held", rd_ready, 0);
    chk(!upd_ready, "R10", "merge into draining entry refused", upd_ready, 0);
    tick();
    chk(out_valid && out_addr == 6, "R6", "read match drained first", 128'(out_addr), 6);
    chk(!rd_ready, "R6", "read held on output register", rd_ready, 0);
    out_ready = 1'b1;
    for (int i = 0; i < 50 && (rd_valid || upd_valid); i++) tick();
    chk(!rd_valid && !upd_valid, "R10", "collided update accepted later", {rd_valid, upd_valid}, 0);
    do_flush();

    // R7 flush refuses updates
    out_ready = 1'b0;
    put(2, rnd_word());
    flush_req = 1'b1; tick(); flush_req = 1'b0;
    upd_valid = 1'b1; upd_line = 16'd57; upd_word = rnd_word();
    #1;
    chk(flush_busy && !upd_ready, "R7", "update during flush", {flush_busy, upd_ready}, 2'b10);
    out_ready = 1'b1;
    for (int i = 0; i < 50 && upd_valid; i++) tick();
    chk(!upd_valid && !flush_busy, "R7", "flush completes then accepts", {upd_valid, flush_busy}, 0);
    do_flush();

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if (!upd_valid && ($urandom() % 10) < 6) begin
        upd_valid = 1'b1; upd_line = LINE_W'($urandom() % NLINES); upd_word = rnd_word();
      end
      if (!rd_valid && ($urandom() % 10) == 0) begin
        rd_valid = 1'b1; rd_addr = BA_W'($urandom() % 8);
      end
      out_ready = ($urandom() % 10) < 7;
      flush_req = ($urandom() % 100) == 0;
      tick();
      flush_req = 1'b0;
    end
    for (int i = 0; i < 200 && (upd_valid || rd_valid); i++) begin out_ready = 1'b1; tick(); end
    do_flush();
    for (int i = 0; i < NLINES; i++)
      chk(dram_w[i] == exp_w[i], "R2", $sformatf("final image line %0d", i), dram_w[i], exp_w[i]);
    chk(cnt_data_wr == CNT_W'(acc_cnt), "R9", "data write count", cnt_data_wr, acc_cnt);
    chk(cnt_corr_wr == CNT_W'(burst_cnt), "R9", "correction write count", cnt_corr_wr, burst_cnt);
    done = 1;
    finish_run();
  end
endmodule